// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block times the clock line of an I2C bus master. A sequencer that owns START, STOP and the data bits asks it for one clock phase at a time. It then drives SCL low through an open-drain control, releases it, and counts the programmed number of system-clock cycles. Two strobes tell the sequencer when SDA may be changed and when SDA should be sampled. The block has two kinds of request. A bit request produces one low phase followed by one high phase. A start-hold request keeps SCL released for the hold time after a START.

There are four period counts: a high count and a low count for standard speed, and the same pair for fast speed. A speed-select input chooses the pair when a request is accepted. Each phase adds fixed overhead cycles to the programmed count. The low count starts in the cycle in which the block begins to pull SCL low. The high count advances only while the line is sensed high, so a slave that holds SCL low stretches the high phase. The counts can be changed only while the block is disabled.

Requests use a valid/ready handshake. The sequencer raises `req_valid` with `req_kind` and holds both until it sees `req_ready` at a clock edge. `req_ready` does not depend on `req_valid`. It is high only while the block is enabled and no phase is in progress.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is held or `enable` is low, `scl_drive_low`, `req_ready` and both strobes are low, and the phase counter is cleared.
- R2: A bit request (`req_kind`=0) accepted at a clock edge drives SCL low from the next cycle for exactly low count + 1 cycles.
- R3: After the low phase of a bit request, SCL is released for exactly high count + 8 cycles in which `scl_in` is sensed high, and then `req_ready` rises.
- R4: During a high or start-hold phase, any cycle with `scl_in` low does not advance the count, so each such cycle lengthens the phase by one cycle. `sda_sample_stb` is high only while `scl_in` is high.
- R5: A start-hold request (`req_kind`=1) keeps SCL released for high count + 3 sensed-high cycles and raises no strobe.
- R6: When `fast_sel` is 1 at acceptance, the fast pair is used for the whole request. When it is 0, the standard pair is used.
- R7: Count writes (`cfg_addr` 0 = standard high, 1 = standard low, 2 = fast high, 3 = fast low) take effect only when `enable` is low. A write made while enabled leaves the stored count unchanged.
- R8: `sda_change_stb` is high in the first low cycle of a bit request only. `sda_sample_stb` is high in the last counted high cycle only.
- R9: `req_ready` is high exactly when `enable` is high and no phase is active. A request is taken at an edge where `req_valid` and `req_ready` are both high.
- R10: Dropping `enable` during any phase releases SCL and returns the block to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and permits count writes |
| fast_sel | input | 1 | 1 selects the fast count pair at acceptance |
| cfg_wr | input | 1 | Count write strobe |
| cfg_addr | input | 2 | Count select for a write |
| cfg_wdata | input | CNT_W | Count value for a write |
| req_valid | input | 1 | Phase request valid |
| req_kind | input | 1 | 0 bit clock, 1 start hold |
| req_ready | output | 1 | Request accepted when high with req_valid |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (open drain) |
| sda_change_stb | output | 1 | SDA may change in this cycle |
| sda_sample_stb | output | 1 | SDA should be sampled in this cycle |

## Verification
The assertions check the local relations on every cycle. They check that SCL is released once the block is disabled and that ready never coincides with a driven-low line. They check that the change strobe falls in the first low cycle and that the sample strobe appears only with SCL sensed high. They also check the line state in the cycle after each accepted request kind. Phase lengths, the effect of stretching, the choice of count pair and the blocking of writes while enabled depend on counts across many cycles. These are shown only by the bench, which compares every output against its reference model on every clock and measures phase lengths for each scenario.

// File: rtl/scl_phase_gen_pkg.sv
package scl_phase_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  localparam logic KIND_BIT  = 1'b0;
  localparam logic KIND_HOLD = 1'b1;

  localparam int SEL_STD_HI  = 0;
  localparam int SEL_STD_LO  = 1;
  localparam int SEL_FAST_HI = 2;
  localparam int SEL_FAST_LO = 3;
  localparam int NUM_COUNTS  = 4;

  // Fixed overhead cycles added to the programmed counts
  localparam int LOW_EXTRA  = 1;
  localparam int HIGH_EXTRA = 8;
  localparam int HOLD_EXTRA = 3;
endpackage

// File: rtl/scl_cnt_bank.sv
module scl_cnt_bank
  import scl_phase_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEF_STD_HI  = 4,
  parameter int DEF_STD_LO  = 5,
  parameter int DEF_FAST_HI = 1,
  parameter int DEF_FAST_LO = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             enable,
  input  logic                             cfg_wr,
  input  logic [1:0]                       cfg_addr,
  input  logic [CNT_W-1:0]                 cfg_wdata,
  output logic [NUM_COUNTS-1:0][CNT_W-1:0] counts
);
  localparam logic [NUM_COUNTS-1:0][CNT_W-1:0] RESET_VALS = {
    CNT_W'(DEF_FAST_LO), CNT_W'(DEF_FAST_HI),
    CNT_W'(DEF_STD_LO),  CNT_W'(DEF_STD_HI)
  };

  logic wr_open;
  assign wr_open = cfg_wr && !enable;

  for (genvar g = 0; g < NUM_COUNTS; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        counts[g] <= RESET_VALS[g];
      else if (wr_open && (cfg_addr == 2'(g)))
        counts[g] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_phase_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEF_STD_HI  = 4,
  parameter int DEF_STD_LO  = 5,
  parameter int DEF_FAST_HI = 1,
  parameter int DEF_FAST_LO = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fast_sel,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             req_valid,
  input  logic             req_kind,
  output logic             req_ready,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             sda_change_stb,
  output logic             sda_sample_stb
);
  localparam int CW = CNT_W + 4;

  logic [NUM_COUNTS-1:0][CNT_W-1:0] counts;
  phase_e ph_q, ph_d;
  logic   first_q, fast_q;
  logic   accept, ctr_zero, ctr_load, ctr_dec;
  logic [CW-1:0] ctr_val;
  logic [CNT_W-1:0] lo_now, hi_now, hi_held;

  scl_cnt_bank #(
    .CNT_W(CNT_W), .DEF_STD_HI(DEF_STD_HI), .DEF_STD_LO(DEF_STD_LO),
    .DEF_FAST_HI(DEF_FAST_HI), .DEF_FAST_LO(DEF_FAST_LO)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .counts(counts)
  );

  assign lo_now  = fast_sel ? counts[SEL_FAST_LO] : counts[SEL_STD_LO];
  assign hi_now  = fast_sel ? counts[SEL_FAST_HI] : counts[SEL_STD_HI];
  assign hi_held = fast_q   ? counts[SEL_FAST_HI] : counts[SEL_STD_HI];

  assign req_ready = enable && (ph_q == PH_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    ph_d     = ph_q;
    ctr_load = 1'b0;
    ctr_dec  = 1'b0;
    ctr_val  = '0;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        ctr_load = 1'b1;
        if (req_kind == KIND_HOLD) begin
          ph_d    = PH_HOLD;
          ctr_val = CW'(hi_now) + CW'(HOLD_EXTRA - 1);
        end else begin
          ph_d    = PH_LOW;
          ctr_val = CW'(lo_now) + CW'(LOW_EXTRA - 1);
        end
      end
      PH_LOW: begin
        if (ctr_zero) begin
          ph_d     = PH_HIGH;
          ctr_load = 1'b1;
          ctr_val  = CW'(hi_held) + CW'(HIGH_EXTRA - 1);
        end else begin
          ctr_dec = 1'b1;
        end
      end
      PH_HIGH, PH_HOLD: begin
        if (scl_in) begin
          if (ctr_zero) ph_d = PH_IDLE;
          else          ctr_dec = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  scl_phase_ctr #(.W(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(!enable), .load(ctr_load),
    .load_val(ctr_val), .dec(ctr_dec), .zero(ctr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      first_q <= 1'b0;
      fast_q  <= 1'b0;
    end else if (!enable) begin
      ph_q    <= PH_IDLE;
      first_q <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      first_q <= accept && (req_kind == KIND_BIT);
      if (accept) fast_q <= fast_sel;
    end
  end

  assign scl_drive_low  = (ph_q == PH_LOW);
  assign sda_change_stb = (ph_q == PH_LOW) && first_q;
  assign sda_sample_stb = (ph_q == PH_HIGH) && scl_in && ctr_zero;
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic req_valid,
  input logic req_kind,
  input logic req_ready,
  input logic scl_in,
  input logic scl_drive_low,
  input logic sda_change_stb,
  input logic sda_sample_stb
);
  p_release_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_drive_low);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (enable && !scl_drive_low));

  p_bit_goes_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_kind) |=> scl_drive_low);

  p_hold_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind) |=> (!scl_drive_low && !sda_sample_stb));

  p_change_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> sda_change_stb);

  p_change_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> scl_drive_low);

  p_change_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |=> !sda_change_stb);

  p_sample_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |-> (scl_in && !scl_drive_low && !sda_change_stb));

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req_ready);
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid),
  .req_kind(req_kind), .req_ready(req_ready), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .sda_change_stb(sda_change_stb),
  .sda_sample_stb(sda_sample_stb)
);

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, fast_sel = 1'b0, cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_kind = 1'b0;
  logic req_ready, scl_in, scl_drive_low, sda_change_stb, sda_sample_stb;
  logic stall_now = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign scl_in = !scl_drive_low && !stall_now;

  scl_phase_gen #(.CNT_W(CNT_W)) u_scl_phase_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_kind(req_kind), .req_ready(req_ready),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .sda_change_stb(sda_change_stb), .sda_sample_stb(sda_sample_stb)
  );

  // Reference model: phase letter and remaining counted cycles
  int  m_cnt[4];
  byte m_ph;
  int  m_left;
  bit  m_first, m_fast;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt[0] = 4; m_cnt[1] = 5; m_cnt[2] = 1; m_cnt[3] = 2;
      m_ph = "I"; m_left = 0; m_first = 0; m_fast = 0;
    end else if (!enable) begin
      if (cfg_wr) m_cnt[cfg_addr] = int'(cfg_wdata);
      m_ph = "I"; m_left = 0; m_first = 0; m_fast = 0;
    end else begin
      case (m_ph)
        "I": begin
          m_first = 0;
          if (req_valid) begin
            m_fast = fast_sel;
            if (req_kind) begin
              m_ph = "S"; m_left = m_cnt[fast_sel ? 2 : 0] + 3;
            end else begin
              m_ph = "L"; m_left = m_cnt[fast_sel ? 3 : 1] + 1; m_first = 1;
            end
          end
        end
        "L": begin
          m_first = 0;
          m_left--;
          if (m_left == 0) begin
            m_ph = "H"; m_left = m_cnt[m_fast ? 2 : 0] + 8;
          end
        end
        default: if (scl_in) begin
          m_left--;
          if (m_left == 0) m_ph = "I";
        end
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 drive", int'(scl_drive_low), int'(m_ph == "L"));
      check("R9 ready", int'(req_ready), int'(enable && m_ph == "I"));
      check("R8 change", int'(sda_change_stb), int'(m_ph == "L" && m_first));
      check("R8 sample", int'(sda_sample_stb),
            int'(m_ph == "H" && scl_in && m_left == 1));
    end
  end

  task automatic cfg_write(input int a, input int v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 2'(a); cfg_wdata = CNT_W'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_req(input bit kind, input bit fast, input int stalls,
                         output int lo, output int hi);
    int left = stalls;
    lo = 0; hi = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; fast_sel = fast;
    @(negedge clk);
    req_valid = 1'b0; fast_sel = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (scl_drive_low) lo++;
      else if (req_ready) break;
      else begin
        hi++;
        stall_now = (left > 0);
        if (left > 0) left--;
      end
      @(negedge clk);
    end
    stall_now = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int lo, hi;
    #3;
    check("R1 reset drive", int'(scl_drive_low), 0);
    check("R1 reset ready", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 disabled ready", int'(req_ready), 0);
    cfg_write(0, 3); cfg_write(1, 4); cfg_write(2, 1); cfg_write(3, 2);
    enable = 1'b1;
    @(negedge clk);
    check("R9 idle ready", int'(req_ready), 1);

    run_req(0, 0, 0, lo, hi);
    check("R2 std low", lo, 5);
    check("R3 std high", hi, 11);
    run_req(0, 1, 0, lo, hi);
    check("R6 fast low", lo, 3);
    check("R6 fast high", hi, 9);
    run_req(1, 0, 0, lo, hi);
    check("R5 std hold low", lo, 0);
    check("R5 std hold", hi, 6);
    run_req(1, 1, 0, lo, hi);
    check("R5 fast hold", hi, 4);
    run_req(0, 0, 5, lo, hi);
    check("R4 stretched high", hi, 16);
    run_req(1, 0, 2, lo, hi);
    check("R4 stretched hold", hi, 8);

    cfg_write(1, 9);
    run_req(0, 0, 0, lo, hi);
    check("R7 write while enabled ignored", lo, 5);
    enable = 1'b0;
    cfg_write(1, 9);
    enable = 1'b1;
    run_req(0, 0, 0, lo, hi);
    check("R7 write while disabled", lo, 10);

    @(negedge clk);
    req_valid = 1'b1; req_kind = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 low before abort", int'(scl_drive_low), 1);
    enable = 1'b0;
    @(negedge clk);
    check("R10 released", int'(scl_drive_low), 0);
    check("R1 ready off", int'(req_ready), 0);
    enable = 1'b1;
    run_req(0, 1, 0, lo, hi);
    check("R10 clean after abort low", lo, 3);
    check("R10 clean after abort high", hi, 9);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule